// File: doc/BRIEF.md
# Device Refresh Row and Bank Counter with Self-Refresh Engine

This block keeps the refresh position inside a DRAM device. A refresh row register supplies the row for every refresh. A refresh bank pointer walks a fixed 32-step bank order. When the controller sends a refresh-activate, it supplies the bank and the block opens that bank at the stored row. When the commanded bank is the highest one, the row register moves on, so the next pass through the banks refreshes the next row.

In the low-power states the block refreshes the core by itself. An internal tick counter paces the work. On each tick, the engine activates the next bank of the order at the stored row. A fixed number of cycles later it precharges that bank. Powerdown always starts this engine. Nap starts it only when the nap self-refresh enable is set. When the device leaves the low-power state, the engine finishes any open activate with its precharge. It then stops at the next tick boundary.

The command input is a valid/ready stream with back-pressure. `ref_ready` is low while self-refresh is requested or the engine is still running. A command is taken only on a cycle where both `ref_valid` and `ref_ready` are high. While ready is low, the controller must hold the command, and it has no effect. The core strobes are single-cycle pulses. The core always accepts them, so they carry no back-pressure.

Top module: `refcnt_top`

## Requirements
- R1: After reset, `refresh_row` is 0, both core strobes are low, `ref_ready` is high in the active state, and the bank pointer is at the first step of the order, so the first self-refresh activate uses bank 12 at row 0.
- R2: An accepted command gives a one-cycle `core_act` on the following cycle. It carries the commanded bank and the row register value from before the command.
- R3: An accepted command for the highest bank (all ones, 31 by default) increments `refresh_row` in the same cycle that `core_act` appears, and resets the bank pointer to the first step. Any other bank leaves the row unchanged.
- R4: `ref_ready` is low while self-refresh is requested or the engine is not idle. A `ref_valid` raised during that time produces no activate.
- R5: `pwr_state` encoding: 0 = active, 1 = nap, 2 = powerdown, 3 = treated as active. Self-refresh runs in powerdown. It runs in nap only when `nap_sr_en` is 1. In nap with `nap_sr_en` at 0, no strobe appears and `ref_ready` stays high.
- R6: The first self-refresh activate appears TICK_CYCLES cycles after the cycle in which self-refresh is first requested. Later activates come exactly TICK_CYCLES cycles apart.
- R7: Each self-refresh activate is followed TRAS_CYCLES cycles later by one `core_pre` for the same bank and row. `core_act` and `core_pre` are never high together.
- R8: Self-refresh walks the low-half order 12,10,5,3,0,14,9,7,4,2,13,11,8,6,1,15 and then the same steps plus 16. The row register increments on the precharge of the last step (bank 31).
- R9: When self-refresh is no longer requested, a pending precharge still occurs. No further activate appears. `ref_ready` returns high exactly TICK_CYCLES cycles after the last activate.
- R10: `refresh_row` wraps from its maximum value to 0 and otherwise changes only by +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_state | input | 2 | Power state: 0 active, 1 nap, 2 powerdown |
| nap_sr_en | input | 1 | Enables self-refresh in nap |
| ref_valid | input | 1 | Refresh-activate command valid |
| ref_ready | output | 1 | Command accepted when high together with valid |
| ref_bank | input | BANK_BITS | Bank of the refresh-activate command |
| core_act | output | 1 | One-cycle activate strobe to the core |
| core_pre | output | 1 | One-cycle precharge strobe to the core |
| core_bank | output | BANK_BITS | Bank for the strobe |
| core_row | output | ROW_BITS | Row for the strobe |
| refresh_row | output | ROW_BITS | Current refresh row register |

## Verification
The bench builds the block with BANK_BITS 5, ROW_BITS 3, TICK_CYCLES 16 and TRAS_CYCLES 4. A tick period of 16 cycles makes a full 33-activate pass through the bank order short. That pass covers the row increment after bank 31 and the restart of the order. A 3-bit row register brings the row wrap within eight highest-bank commands. A 4-cycle precharge delay leaves room to change the power state while an activate is open, so the exit path is exercised with a precharge pending.

// File: rtl/refcnt_pkg.sv
package refcnt_pkg;

  localparam logic [1:0] PWR_ACTIVE = 2'd0;
  localparam logic [1:0] PWR_NAP    = 2'd1;
  localparam logic [1:0] PWR_DOWN   = 2'd2;

  typedef enum logic [1:0] {
    SR_IDLE = 2'd0,
    SR_WAIT = 2'd1,
    SR_OPEN = 2'd2
  } sr_state_e;

  // Low half of the bank walk; steps skip by two to avoid neighbour banks.
  function automatic logic [3:0] order_low(input logic [3:0] step);
    logic [3:0] b;
    case (step)
      4'd0:  b = 4'd12;
      4'd1:  b = 4'd10;
      4'd2:  b = 4'd5;
      4'd3:  b = 4'd3;
      4'd4:  b = 4'd0;
      4'd5:  b = 4'd14;
      4'd6:  b = 4'd9;
      4'd7:  b = 4'd7;
      4'd8:  b = 4'd4;
      4'd9:  b = 4'd2;
      4'd10: b = 4'd13;
      4'd11: b = 4'd11;
      4'd12: b = 4'd8;
      4'd13: b = 4'd6;
      4'd14: b = 4'd1;
      default: b = 4'd15;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/refcnt_order.sv
module refcnt_order
  import refcnt_pkg::*;
#(
  parameter int BANK_BITS = 5
) (
  input  logic [BANK_BITS-1:0] pos,
  output logic [BANK_BITS-1:0] bank
);

  // Upper pointer bits pass through; lower four index the fixed walk.
  generate
    if (BANK_BITS == 4) begin : g_flat
      assign bank = order_low(pos);
    end else begin : g_split
      assign bank = {pos[BANK_BITS-1:4], order_low(pos[3:0])};
    end
  endgenerate

endmodule

// File: rtl/refcnt_timebase.sv
module refcnt_timebase #(
  parameter int TICK_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/refcnt_sr_fsm.sv
module refcnt_sr_fsm
  import refcnt_pkg::*;
#(
  parameter int TRAS_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic tick,
  output logic run,
  output logic fire_act,
  output logic fire_pre
);

  localparam int RW = (TRAS_CYCLES > 1) ? $clog2(TRAS_CYCLES + 1) : 1;
  localparam logic [RW-1:0] RAS_LAST = RW'(TRAS_CYCLES - 1);

  sr_state_e     state_q;
  logic [RW-1:0] ras_q;

  always_comb begin
    run      = (state_q != SR_IDLE);
    fire_act = (state_q == SR_WAIT) && tick && want;
    fire_pre = (state_q == SR_OPEN) && (ras_q == RAS_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SR_IDLE;
      ras_q   <= '0;
    end else begin
      case (state_q)
        SR_IDLE: if (want) state_q <= SR_WAIT;
        SR_WAIT: begin
          if (tick) begin
            if (want) begin
              state_q <= SR_OPEN;
              ras_q   <= '0;
            end else begin
              state_q <= SR_IDLE;
            end
          end
        end
        SR_OPEN: begin
          if (fire_pre) state_q <= SR_WAIT;
          else          ras_q   <= ras_q + RW'(1);
        end
        default: state_q <= SR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/refcnt_top.sv
module refcnt_top
  import refcnt_pkg::*;
#(
  parameter int BANK_BITS   = 5,
  parameter int ROW_BITS    = 9,
  parameter int TICK_CYCLES = 1024,
  parameter int TRAS_CYCLES = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           pwr_state,
  input  logic                 nap_sr_en,
  input  logic                 ref_valid,
  output logic                 ref_ready,
  input  logic [BANK_BITS-1:0] ref_bank,
  output logic                 core_act,
  output logic                 core_pre,
  output logic [BANK_BITS-1:0] core_bank,
  output logic [ROW_BITS-1:0]  core_row,
  output logic [ROW_BITS-1:0]  refresh_row
);

  localparam logic [BANK_BITS-1:0] BANK_MAX = '1;
  localparam logic [BANK_BITS-1:0] POS_LAST = '1;

  logic                 sr_want;
  logic                 sr_run;
  logic                 sr_tick;
  logic                 fire_act;
  logic                 fire_pre;
  logic                 ext_hit;
  logic [BANK_BITS-1:0] ptr_q;
  logic [BANK_BITS-1:0] sr_bank;
  logic [ROW_BITS-1:0]  row_q;

  assign sr_want = (pwr_state == PWR_DOWN) ||
                   ((pwr_state == PWR_NAP) && nap_sr_en);

  assign ref_ready = !sr_run && !sr_want;
  assign ext_hit   = ref_valid && ref_ready;

  refcnt_timebase #(.TICK_CYCLES(TICK_CYCLES)) u_tb (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (sr_run),
    .tick (sr_tick)
  );

  refcnt_sr_fsm #(.TRAS_CYCLES(TRAS_CYCLES)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .want    (sr_want),
    .tick    (sr_tick),
    .run     (sr_run),
    .fire_act(fire_act),
    .fire_pre(fire_pre)
  );

  refcnt_order #(.BANK_BITS(BANK_BITS)) u_order (
    .pos (ptr_q),
    .bank(sr_bank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q     <= '0;
      ptr_q     <= '0;
      core_act  <= 1'b0;
      core_pre  <= 1'b0;
      core_bank <= '0;
      core_row  <= '0;
    end else begin
      core_act <= 1'b0;
      core_pre <= 1'b0;
      if (ext_hit) begin
        core_act  <= 1'b1;
        core_bank <= ref_bank;
        core_row  <= row_q;
        if (ref_bank == BANK_MAX) begin
          row_q <= row_q + ROW_BITS'(1);
          ptr_q <= '0;
        end
      end else if (fire_act) begin
        core_act  <= 1'b1;
        core_bank <= sr_bank;
        core_row  <= row_q;
      end else if (fire_pre) begin
        core_pre  <= 1'b1;
        core_bank <= sr_bank;
        core_row  <= row_q;
        ptr_q     <= ptr_q + BANK_BITS'(1);
        if (ptr_q == POS_LAST) row_q <= row_q + ROW_BITS'(1);
      end
    end
  end

  assign refresh_row = row_q;

endmodule

// File: rtl/refcnt_checker.sv
module refcnt_checker #(
  parameter int BANK_BITS   = 5,
  parameter int ROW_BITS    = 9,
  parameter int TRAS_CYCLES = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ref_valid,
  input logic                 ref_ready,
  input logic [BANK_BITS-1:0] ref_bank,
  input logic                 core_act,
  input logic                 core_pre,
  input logic [BANK_BITS-1:0] core_bank,
  input logic [ROW_BITS-1:0]  core_row,
  input logic [ROW_BITS-1:0]  refresh_row
);

  localparam int SW = $clog2(TRAS_CYCLES + 3);
  localparam logic [SW-1:0] SAT = SW'(TRAS_CYCLES + 1);

  logic [SW-1:0]        since_q;
  logic [BANK_BITS-1:0] act_bank_q;
  logic [ROW_BITS-1:0]  act_row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= SAT;
      act_bank_q <= '0;
      act_row_q  <= '0;
    end else if (core_act) begin
      since_q    <= SW'(1);
      act_bank_q <= core_bank;
      act_row_q  <= core_row;
    end else if (since_q != SAT) begin
      since_q <= since_q + SW'(1);
    end
  end

  AST_EXT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_ready) |=> (core_act && core_bank == $past(ref_bank))) else $error("ext accept"); // R2

  AST_IDLE_NO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready |=> !core_pre) else $error("pre while idle"); // R4

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(refresh_row) |-> (refresh_row == ROW_BITS'($past(refresh_row) + 1'b1))) else $error("row step"); // R10

  AST_PRE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    core_pre |-> (since_q == SW'(TRAS_CYCLES))) else $error("pre delay"); // R7

  AST_PRE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    core_pre |-> (core_bank == act_bank_q && core_row == act_row_q)) else $error("pre target"); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_act && core_pre)) else $error("strobes overlap"); // R7

endmodule

bind refcnt_top refcnt_checker #(
  .BANK_BITS  (BANK_BITS),
  .ROW_BITS   (ROW_BITS),
  .TRAS_CYCLES(TRAS_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_valid  (ref_valid),
  .ref_ready  (ref_ready),
  .ref_bank   (ref_bank),
  .core_act   (core_act),
  .core_pre   (core_pre),
  .core_bank  (core_bank),
  .core_row   (core_row),
  .refresh_row(refresh_row)
);

// File: tb/refcnt_top_tb_top.sv
module refcnt_top_tb_top;

  localparam int BB   = 5;
  localparam int RB   = 3;
  localparam int TICK = 16;
  localparam int TRAS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    pwr_state = 2'd0;
  logic          nap_sr_en = 1'b0;
  logic          ref_valid = 1'b0;
  logic          ref_ready;
  logic [BB-1:0] ref_bank = '0;
  logic          core_act;
  logic          core_pre;
  logic [BB-1:0] core_bank;
  logic [RB-1:0] core_row;
  logic [RB-1:0] refresh_row;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int last_act = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refcnt_top #(.BANK_BITS(BB), .ROW_BITS(RB), .TICK_CYCLES(TICK), .TRAS_CYCLES(TRAS)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .nap_sr_en(nap_sr_en),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_bank(ref_bank),
    .core_act(core_act), .core_pre(core_pre), .core_bank(core_bank),
    .core_row(core_row), .refresh_row(refresh_row)
  );

  function automatic int exp_bank(input int step);
    int lo[16] = '{12, 10, 5, 3, 0, 14, 9, 7, 4, 2, 13, 11, 8, 6, 1, 15};
    return lo[step % 16] + ((step % 32) >= 16 ? 16 : 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_evt(input bit is_pre, output int at);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(is_pre ? core_pre : core_act) && n < 2000);
    at = cyc;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(core_act == 0 && core_pre == 0, "R1 strobes", int'({core_act, core_pre}), 0);
    chk(refresh_row == 0, "R1 row", int'(refresh_row), 0);
    chk(ref_ready == 1, "R1 ready", int'(ref_ready), 1);
  endtask

  task automatic t_ext();
    ref_valid = 1; ref_bank = 5'd5;
    @(negedge clk);
    ref_valid = 0;
    chk(core_act == 1 && core_bank == 5, "R2 act bank", int'(core_bank), 5);
    chk(core_row == 0 && refresh_row == 0, "R3 no row step", int'(refresh_row), 0);
    @(negedge clk);
    chk(core_act == 0, "R2 single pulse", int'(core_act), 0);
    for (int i = 0; i < 8; i++) begin
      ref_valid = 1; ref_bank = 5'd31;
      @(negedge clk);
      ref_valid = 0;
      chk(core_act == 1 && core_row == RB'(i), "R3 act row", int'(core_row), i);
      chk(refresh_row == RB'(i + 1), "R3 row step", int'(refresh_row), (i + 1) % 8);
    end
    chk(refresh_row == 0, "R10 wrap", int'(refresh_row), 0);
  endtask

  task automatic t_nap_off();
    int acts = 0;
    pwr_state = 2'd1; nap_sr_en = 0;
    repeat (3 * TICK) begin
      @(negedge clk);
      if (core_act || core_pre) acts++;
    end
    chk(acts == 0, "R5 nap no enable strobes", acts, 0);
    chk(ref_ready == 1, "R5 nap no enable ready", int'(ref_ready), 1);
  endtask

  task automatic t_selfref();
    int start, a, p;
    pwr_state = 2'd2;
    start = cyc + 1;
    @(negedge clk);
    chk(ref_ready == 0, "R4 ready low", int'(ref_ready), 0);
    ref_valid = 1; ref_bank = 5'd3;
    @(negedge clk);
    chk(core_act == 0, "R4 held command ignored", int'(core_act), 0);
    ref_valid = 0;
    for (int i = 0; i < 33; i++) begin
      wait_evt(0, a);
      if (i == 0) chk(a == start + TICK, "R6 first act", a, start + TICK);
      else        chk(a == last_act + TICK, "R6 act spacing", a - last_act, TICK);
      chk(core_bank == BB'(exp_bank(i)), "R8 bank order", int'(core_bank), exp_bank(i));
      chk(core_row == RB'(i / 32), "R8 act row", int'(core_row), i / 32);
      last_act = a;
      wait_evt(1, p);
      chk(p == a + TRAS, "R7 pre delay", p - a, TRAS);
      chk(core_bank == BB'(exp_bank(i)), "R7 pre bank", int'(core_bank), exp_bank(i));
    end
    chk(refresh_row == 1, "R8 row after 31", int'(refresh_row), 1);
  endtask

  task automatic t_exit();
    int a, p, extra = 0;
    wait_evt(0, a);
    chk(core_bank == BB'(exp_bank(33)), "R8 bank order cont", int'(core_bank), exp_bank(33));
    pwr_state = 2'd0;
    wait_evt(1, p);
    chk(p == a + TRAS, "R9 pending pre", p - a, TRAS);
    while (cyc < a + TICK - 1) @(negedge clk);
    chk(ref_ready == 0, "R9 ready still low", int'(ref_ready), 0);
    @(negedge clk);
    chk(ref_ready == 1, "R9 ready back", int'(ref_ready), 1);
    repeat (2 * TICK) begin
      @(negedge clk);
      if (core_act || core_pre) extra++;
    end
    chk(extra == 0, "R9 engine stopped", extra, 0);
  endtask

  task automatic t_nap_on();
    int a;
    pwr_state = 2'd1; nap_sr_en = 1;
    wait_evt(0, a);
    chk(core_bank == BB'(exp_bank(34)), "R5 nap enabled act", int'(core_bank), exp_bank(34));
    pwr_state = 2'd0;
    repeat (TICK + 2) @(negedge clk);
    chk(ref_ready == 1, "R5 nap exit ready", int'(ref_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ext();
    t_nap_off();
    pwr_state = 2'd0;
    @(negedge clk);
    t_selfref();
    t_exit();
    t_nap_on();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule